// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Overflow Flag

This block is a signed arithmetic unit for fixed-point signal processing. Each accepted operation takes two 32-bit two's-complement operands, M and N, and a 2-bit operation code. It returns M plus N or M minus N. Two of the codes first double N, and that doubling also saturates. Every stage clamps to the signed range instead of wrapping, so an overflowing result lands on the nearest value that can be represented.

A sticky overflow flag records that saturation happened somewhere in a run of operations. Software can then run a long sequence and test the flag once at the end. The flag changes only in two ways: a saturation event sets it, and an explicit write port clears or loads it. It can be read at any time. No other condition flags are produced. Operand results are registered on the valid strobe and appear one clock later.

The flag is held by a two-state machine with states `Q_CLR` and `Q_SET`. Its transitions are:
- `EVT_SAT`: a saturation moves it to `Q_SET` from either state.
- `EVT_WR_SET`: a write of 1 moves it to `Q_SET`.
- `EVT_WR_CLR`: a write of 0 with no saturation moves it to `Q_CLR`.
- `EVT_NONE`: with neither a saturation nor a write, it holds its state.

Top module: `satq_alu`

## Requirements
- R1: Code 2'b00 yields M + N, clamped to the signed 32-bit range.
- R2: Code 2'b01 yields M − N, clamped to the signed 32-bit range.
- R3: Code 2'b10 clamps 2·N to the signed range, then yields M plus the clamped value, again clamped.
- R4: Code 2'b11 clamps 2·N to the signed range, then yields M minus the clamped value, again clamped.
- R5: A positive overflow gives 0x7FFFFFFF and a negative overflow gives 0x80000000. When both the doubling and the final step saturate, the result is the final step applied to the clamped doubled value.
- R6: `q_flag` becomes 1 in the cycle after an accepted operation in which the doubling or the final add/subtract saturated.
- R7: Once `q_flag` is 1, it stays 1 through any number of later operations until a write through the flag port.
- R8: With `q_wr_en` high, `q_flag` takes `q_wr_val` on the next cycle. If a saturation happens in the same cycle, the flag ends up 1.
- R9: After reset, `q_flag`, `out_valid` and `out_result` are all 0.
- R10: An operation presented with `in_valid` appears on `out_result` one cycle later with `out_valid` high. When `in_valid` is low, `out_result` holds its value, `out_valid` is low, and operand changes do not affect `q_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code (00 add, 01 sub, 10 double-add, 11 double-sub) |
| in_m | input | 32 | First operand M, signed |
| in_n | input | 32 | Second operand N, signed |
| q_wr_en | input | 1 | Flag write enable |
| q_wr_val | input | 1 | Value written to the flag |
| out_result | output | 32 | Registered saturated result |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `in_valid`, `in_op`, the operands and the flag-write inputs are known (not X) at every rising edge after reset. The bench drives every input on the falling edge from a single task, so that assumption holds. The flag properties also assume that a write is a one-cycle pulse judged at that edge. The bench holds each write for exactly one cycle, either alone or together with an operation, so it exercises both the write-only case and the case where a write and a saturation coincide.

// File: rtl/satq_pkg.sv
package satq_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } satq_op_e;

    typedef enum logic {
        Q_CLR = 1'b0,
        Q_SET = 1'b1
    } qstate_e;

    typedef enum logic [1:0] {
        EVT_NONE,
        EVT_SAT,
        EVT_WR_SET,
        EVT_WR_CLR
    } qevt_e;

    function automatic logic [31:0] sat_max32();
        return 32'h7FFF_FFFF;
    endfunction
endpackage

// File: rtl/satq_doubler.sv
module satq_doubler #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] n_in,
    output logic [W-1:0] n_out,
    output logic         sat
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic         ovf;
    logic [W-1:0] shifted;

    always_comb begin
        shifted = {n_in[W-2:0], 1'b0};
        ovf     = n_in[W-1] ^ n_in[W-2];
        if (!en) begin
            n_out = n_in;
            sat   = 1'b0;
        end else if (ovf) begin
            n_out = n_in[W-1] ? MINV : MAXV;
            sat   = 1'b1;
        end else begin
            n_out = shifted;
            sat   = 1'b0;
        end
    end
endmodule

// File: rtl/satq_addsub.sv
module satq_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam int       XW   = W + 1;
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [XW-1:0] ax;
    logic [XW-1:0] bx;
    logic [XW-1:0] sx;

    always_comb begin
        ax = {a[W-1], a};
        bx = {b[W-1], b};
        sx = sub ? (ax - bx) : (ax + bx);
        if (sx[XW-1] != sx[XW-2]) begin
            y   = sx[XW-1] ? MINV : MAXV;
            sat = 1'b1;
        end else begin
            y   = sx[W-1:0];
            sat = 1'b0;
        end
    end
endmodule

// File: rtl/satq_flag_fsm.sv
module satq_flag_fsm
    import satq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sat_evt,
    input  logic wr_en,
    input  logic wr_val,
    output logic q
);
    qstate_e state, state_nxt;
    qevt_e   evt;

    always_comb begin
        if (sat_evt)
            evt = EVT_SAT;
        else if (wr_en && wr_val)
            evt = EVT_WR_SET;
        else if (wr_en)
            evt = EVT_WR_CLR;
        else
            evt = EVT_NONE;
    end

    always_comb begin
        state_nxt = state;
        unique case (evt)
            EVT_SAT:    state_nxt = Q_SET;
            EVT_WR_SET: state_nxt = Q_SET;
            EVT_WR_CLR: state_nxt = Q_CLR;
            EVT_NONE:   state_nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= Q_CLR;
        else
            state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            Q_CLR: q = 1'b0;
            Q_SET: q = 1'b1;
        endcase
    end
endmodule

// File: rtl/satq_alu.sv
module satq_alu
    import satq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_m,
    input  logic [W-1:0] in_n,
    input  logic         q_wr_en,
    input  logic         q_wr_val,
    output logic [W-1:0] out_result,
    output logic         out_valid,
    output logic         q_flag
);
    satq_op_e     op;
    logic         dbl_en;
    logic         sub_en;
    logic [W-1:0] n_eff;
    logic         dbl_sat;
    logic [W-1:0] sum;
    logic         fin_sat;
    logic         sat_any;

    always_comb begin
        op     = satq_op_e'(in_op);
        dbl_en = (op == OP_DADD) || (op == OP_DSUB);
        sub_en = (op == OP_SUB)  || (op == OP_DSUB);
    end

    satq_doubler #(.W(W)) u_dbl (
        .en    (dbl_en),
        .n_in  (in_n),
        .n_out (n_eff),
        .sat   (dbl_sat)
    );

    satq_addsub #(.W(W)) u_as (
        .sub (sub_en),
        .a   (in_m),
        .b   (n_eff),
        .y   (sum),
        .sat (fin_sat)
    );

    assign sat_any = in_valid && (dbl_sat || fin_sat);

    satq_flag_fsm u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .sat_evt (sat_any),
        .wr_en   (q_wr_en),
        .wr_val  (q_wr_val),
        .q       (q_flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_result <= sum;
        end
    end
endmodule

// File: rtl/satq_alu_chk.sv
module satq_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   in_op,
    input logic [W-1:0] in_m,
    input logic [W-1:0] in_n,
    input logic         q_wr_en,
    input logic         q_wr_val,
    input logic [W-1:0] out_result,
    input logic         out_valid,
    input logic         q_flag
);
    AST_ADD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && (in_m[W-1] != in_n[W-1])) |=> (out_result == $past(in_m + in_n))); // R1
    AST_Q_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_flag) |-> ($past(in_valid) || $past(q_wr_en))); // R6
    AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_wr_en) |=> q_flag); // R7
    AST_Q_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr_en && q_wr_val) |=> q_flag); // R8
    AST_Q_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr_en && !q_wr_val && !in_valid) |=> !q_flag); // R8
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result))); // R10
endmodule

bind satq_alu satq_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_satq_alu.sv
module tb_satq_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_m = '0;
    logic [31:0] in_n = '0;
    logic        q_wr_en = 1'b0;
    logic        q_wr_val = 1'b0;
    logic [31:0] out_result;
    logic        out_valid;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_res = '0;
    logic        exp_q = 1'b0;
    logic        exp_v = 1'b0;

    always #2 clk = ~clk;

    satq_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_m(in_m), .in_n(in_n), .q_wr_en(q_wr_en), .q_wr_val(q_wr_val),
        .out_result(out_result), .out_valid(out_valid), .q_flag(q_flag)
    );

    function automatic longint clampv(input longint v, output bit s);
        s = 1'b0;
        if (v > 64'sd2147483647) begin s = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin s = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    task automatic model(input logic [1:0] op, input logic [31:0] m, input logic [31:0] n,
                         output logic [31:0] r, output bit s);
        longint a, b, y;
        bit s1, s2;
        a = longint'($signed(m));
        b = longint'($signed(n));
        s1 = 1'b0;
        if (op[1]) b = clampv(b * 2, s1);
        y = op[0] ? (a - b) : (a + b);
        y = clampv(y, s2);
        r = y[31:0];
        s = s1 | s2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] m,
                        input logic [31:0] n, input logic we, input logic wv, input string tag);
        logic [31:0] r;
        bit s;
        in_valid = v; in_op = op; in_m = m; in_n = n; q_wr_en = we; q_wr_val = wv;
        model(op, m, n, r, s);
        @(posedge clk);
        exp_v = v;
        if (v) exp_res = r;
        if (v && s) exp_q = 1'b1;
        else if (we) exp_q = wv;
        @(negedge clk);
        in_valid = 1'b0; q_wr_en = 1'b0;
        chk({tag, " result"}, out_result, exp_res);
        chk({tag, " valid"}, {31'd0, out_valid}, {31'd0, exp_v});
        chk({tag, " qflag"}, {31'd0, q_flag}, {31'd0, exp_q});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset result", out_result, 32'h0);
        chk("R9 reset valid", {31'd0, out_valid}, 32'h0);
        chk("R9 reset qflag", {31'd0, q_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 2'b00, 32'd5, 32'd7, 0, 0, "R1 add");
        step(1, 2'b00, 32'hFFFF_FFF0, 32'd3, 0, 0, "R1 add neg");
        step(1, 2'b01, 32'd10, 32'd3, 0, 0, "R2 sub");
        step(1, 2'b10, 32'd100, 32'd21, 0, 0, "R3 dadd");
        step(1, 2'b11, 32'd100, 32'd21, 0, 0, "R4 dsub");
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0, 0, "R5 R6 add pos clamp");
        step(0, 2'b00, 32'd1, 32'd1, 1, 0, "R8 write clear");
        step(1, 2'b01, 32'h8000_0000, 32'd1, 0, 0, "R5 R6 sub neg clamp");
        for (int i = 0; i < 6; i++)
            step(1, 2'(i % 4), 32'd1000 + i, 32'd7, 0, 0, "R7 sticky run");
        step(0, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R10 hold idle");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R8 write clear");
        step(1, 2'b10, 32'd0, 32'h4000_0000, 0, 0, "R3 R6 double clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R8 write clear");
        step(1, 2'b10, 32'h8000_0000, 32'h4000_0000, 0, 0, "R3 R6 double only sat");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R8 write clear");
        step(1, 2'b11, 32'd0, 32'hC000_0000, 0, 0, "R4 exact double then clamp");
        step(1, 2'b11, 32'h7FFF_FFFF, 32'hC000_0000, 0, 0, "R4 max minus min");
        step(1, 2'b11, 32'h8000_0000, 32'h4000_0000, 0, 0, "R5 both stages");
        step(1, 2'b10, 32'h7FFF_FFFF, 32'h4000_0000, 0, 0, "R5 both stages pos");
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd5, 1, 0, "R8 sat beats write");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R8 write clear");
        step(0, 2'b00, 32'd0, 32'd0, 1, 1, "R8 write set");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R8 write clear");
        step(0, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R10 idle no flag");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 5 == 0) b = {b[31], b[31], b[29:0]};
            step(($urandom % 4) != 0, 2'($urandom), a, b, (i % 17) == 0, 1'($urandom),
                 "R1 R2 R3 R4 R6 R7 random");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule